// File: doc/BRIEF.md
# Debounced Keyboard Matrix Scanner

This block walks a 64-position switch matrix. It puts a 6-bit address on the matrix and holds each address for a programmable number of clock enables. At the end of each hold it samples two returns: one for the key at that address, and one for a modifier row. Each key keeps two bits of history, its raw value from the previous sweep and its accepted state. With debouncing on, a key is accepted only after it reads the same way on two sweeps in a row. With debouncing off, one reading is enough. Shift and control are read from two fixed slots on the modifier return.

When a key goes from released to accepted, the block forms an 8-bit code: the address in bits 5:0, shift in bit 6 and control in bit 7. The code is offered on a valid/ready output and the interrupt line is raised. The consumer may apply back-pressure for as long as it likes; the code and the interrupt stay up until a handshake. If a newer key is accepted while a code is still pending, the newer code replaces it and a sticky overrun flag is set, so the pending data is not frozen under back-pressure. If a handshake and a new key fall on the same cycle, the new code becomes pending and no overrun is flagged. Three status pins read active-low: the last accepted key is still held, shift is held, and overrun. Only the status-clear strobe resets overrun.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: During and right after reset, scan_addr is 0, key_valid and irq are 0, and held_n, shift_n and overrun_n are 1.
- R2: While scan_en and tick are both high, scan_addr steps by one after every DWELL clock enables and wraps from 63 to 0. A cycle with tick low does not advance the hold count.
- R3: With debounce_en low, one sample that reads key_ret high for a released key accepts it. On that same sampling edge key_valid and irq rise and key_code[5:0] takes the key's address.
- R4: With debounce_en high, a key is accepted only when two consecutive sweeps read it pressed. A press seen on a single sweep is never accepted.
- R5: held_n goes low when a key is accepted. It returns high after that key reads released on one sweep (debounce off) or on two consecutive sweeps (debounce on).
- R6: mod_ret is read as shift at address SHIFT_SLOT (default 62) and as control at address CTRL_SLOT (default 63). The states current at acceptance appear in key_code bit 6 (shift) and bit 7 (control). shift_n is low while the latest shift reading is pressed.
- R7: key_valid and irq stay high until a cycle with key_ready high. key_valid then falls on the next edge. The code stays unchanged until then, unless a newer key is accepted.
- R8: Accepting a key while an earlier code is still pending, with no handshake that cycle, replaces the code and drives overrun_n low. overrun_n stays low through handshakes and returns high only after a cycle with stat_clr high.
- R9: With scan_en low, scan_addr holds its value and no key is sampled or accepted.
- R10: A key that stays pressed raises no further request after its code is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable for the address hold count |
| scan_en | input | 1 | Enables matrix scanning |
| debounce_en | input | 1 | Enables two-sweep debouncing |
| scan_addr | output | 6 | Matrix address being scanned |
| key_ret | input | 1 | Return of the addressed key, high when closed |
| mod_ret | input | 1 | Modifier row return, high when closed |
| key_valid | output | 1 | A key code is pending |
| key_ready | input | 1 | Consumer takes the pending code |
| key_code | output | 8 | {control, shift, address} of the accepted key |
| irq | output | 1 | Keyboard interrupt request |
| held_n | output | 1 | Low while the last accepted key is still held |
| shift_n | output | 1 | Low while shift is held |
| overrun_n | output | 1 | Low after an overrun, until cleared |
| stat_clr | input | 1 | Status-clear strobe for the overrun flag |

## Verification
The properties assume that key_ret and mod_ret are synchronous to clk and settle from the current scan_addr before each edge. They also assume that stat_clr and key_ready are ordinary clocked levels. The bench models the matrix as a continuous function of scan_addr over a key vector it owns, and it changes that vector, the modifiers and the control inputs only on falling edges. Each wait covers exactly a whole number of sweeps, so every key is sampled a known number of times. The debounce and release windows can therefore be checked cycle-exactly.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int KEY_ADDR_W = 6;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_SET   = 2'd1,
    ST_CLEAR = 2'd2
  } kbd_state_act_e;
endpackage

// File: rtl/kbd_scan_timer.sv
module kbd_scan_timer #(
  parameter int ADDR_W = 6,
  parameter int DWELL  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              scan_en,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              smp_stb
);
  logic              run;
  logic [ADDR_W-1:0] addr_q;

  assign run = tick && scan_en;

  generate
    if (DWELL > 1) begin : g_dwell
      localparam int CW = $clog2(DWELL);
      localparam logic [CW-1:0] LAST = CW'(DWELL - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (run) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      assign smp_stb = run && (cnt_q == LAST);
    end else begin : g_nodwell
      assign smp_stb = run;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (smp_stb) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign scan_addr = addr_q;
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce
  import kbd_scan_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic              key_ret,
  input  logic              debounce_en,
  output logic              new_state,
  output logic              rise
);
  localparam int KEYS = 1 << ADDR_W;

  logic [KEYS-1:0] prev_v;
  logic [KEYS-1:0] acc_v;
  logic            prev_sel;
  logic            acc_sel;
  kbd_state_act_e  act;

  assign prev_sel = prev_v[smp_addr];
  assign acc_sel  = acc_v[smp_addr];

  always_comb begin
    if (!debounce_en) begin
      act = key_ret ? ST_SET : ST_CLEAR;
    end else if (key_ret && prev_sel) begin
      act = ST_SET;
    end else if (!key_ret && !prev_sel) begin
      act = ST_CLEAR;
    end else begin
      act = ST_HOLD;
    end
  end

  always_comb begin
    case (act)
      ST_SET:   new_state = 1'b1;
      ST_CLEAR: new_state = 1'b0;
      default:  new_state = acc_sel;
    endcase
  end

  assign rise = smp_stb && new_state && !acc_sel;

  generate
    for (genvar i = 0; i < KEYS; i++) begin : g_key
      logic wr;
      logic prev_q;
      logic acc_q;

      assign wr = smp_stb && (smp_addr == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          acc_q  <= 1'b0;
        end else if (wr) begin
          prev_q <= key_ret;
          acc_q  <= new_state;
        end
      end

      assign prev_v[i] = prev_q;
      assign acc_v[i]  = acc_q;
    end
  endgenerate
endmodule

// File: rtl/kbd_event.sv
module kbd_event #(
  parameter int                ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] SHIFT_SLOT = 62,
  parameter logic [ADDR_W-1:0] CTRL_SLOT  = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic              mod_ret,
  input  logic              rise,
  input  logic              new_state,
  input  logic              key_ready,
  input  logic              stat_clr,
  output logic              key_valid,
  output logic [ADDR_W+1:0] key_code,
  output logic              held,
  output logic              shift_dn,
  output logic              overrun,
  output logic              acc_stb
);
  logic              vld_q;
  logic [ADDR_W+1:0] code_q;
  logic [ADDR_W-1:0] last_q;
  logic              held_q;
  logic              shift_q;
  logic              ctrl_q;
  logic              ovr_q;
  logic              xfer;

  assign acc_stb = rise;
  assign xfer    = vld_q && key_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
      ctrl_q  <= 1'b0;
    end else if (smp_stb) begin
      if (smp_addr == SHIFT_SLOT) shift_q <= mod_ret;
      if (smp_addr == CTRL_SLOT)  ctrl_q  <= mod_ret;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
      last_q <= '0;
    end else if (acc_stb) begin
      vld_q  <= 1'b1;
      code_q <= {ctrl_q, shift_q, smp_addr};
      last_q <= smp_addr;
    end else if (xfer) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (acc_stb) begin
      held_q <= 1'b1;
    end else if (smp_stb && (smp_addr == last_q) && !new_state) begin
      held_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (acc_stb && vld_q && !key_ready) begin
      ovr_q <= 1'b1;
    end else if (stat_clr) begin
      ovr_q <= 1'b0;
    end
  end

  assign key_valid = vld_q;
  assign key_code  = code_q;
  assign held      = held_q;
  assign shift_dn  = shift_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbd_scan_pkg::*;
#(
  parameter int                ADDR_W     = KEY_ADDR_W,
  parameter int                DWELL      = 64,
  parameter logic [ADDR_W-1:0] SHIFT_SLOT = 62,
  parameter logic [ADDR_W-1:0] CTRL_SLOT  = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              scan_en,
  input  logic              debounce_en,
  output logic [ADDR_W-1:0] scan_addr,
  input  logic              key_ret,
  input  logic              mod_ret,
  output logic              key_valid,
  input  logic              key_ready,
  output logic [ADDR_W+1:0] key_code,
  output logic              irq,
  output logic              held_n,
  output logic              shift_n,
  output logic              overrun_n,
  input  logic              stat_clr
);
  logic smp_stb;
  logic new_state;
  logic rise;
  logic acc_stb;
  logic held;
  logic shift_dn;
  logic overrun;

  kbd_scan_timer #(
    .ADDR_W(ADDR_W),
    .DWELL (DWELL)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .scan_en  (scan_en),
    .scan_addr(scan_addr),
    .smp_stb  (smp_stb)
  );

  kbd_debounce #(
    .ADDR_W(ADDR_W)
  ) debounce_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .smp_addr   (scan_addr),
    .key_ret    (key_ret),
    .debounce_en(debounce_en),
    .new_state  (new_state),
    .rise       (rise)
  );

  kbd_event #(
    .ADDR_W    (ADDR_W),
    .SHIFT_SLOT(SHIFT_SLOT),
    .CTRL_SLOT (CTRL_SLOT)
  ) event_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .smp_addr (scan_addr),
    .mod_ret  (mod_ret),
    .rise     (rise),
    .new_state(new_state),
    .key_ready(key_ready),
    .stat_clr (stat_clr),
    .key_valid(key_valid),
    .key_code (key_code),
    .held     (held),
    .shift_dn (shift_dn),
    .overrun  (overrun),
    .acc_stb  (acc_stb)
  );

  assign irq       = key_valid;
  assign held_n    = ~held;
  assign shift_n   = ~shift_dn;
  assign overrun_n = ~overrun;
endmodule

// File: rtl/kbd_matrix_scanner_chk.sv
module kbd_matrix_scanner_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en,
  input logic [ADDR_W-1:0] scan_addr,
  input logic              key_valid,
  input logic              key_ready,
  input logic [ADDR_W+1:0] key_code,
  input logic              overrun_n,
  input logic              stat_clr,
  input logic              smp_stb,
  input logic              acc_stb
);
  // R2: the address only ever moves forward by one, with wrap
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scan_addr) |-> scan_addr == $past(scan_addr) + 1'b1);

  // R9: scanning disabled freezes the address
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(scan_addr));

  // R3: a new request appears only after a sampling edge
  assert_accept_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> $past(smp_stb));

  // R7: a pending code is held under back-pressure
  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !key_ready |=> key_valid);

  // R7: code unchanged while pending, unless replaced by a newer key
  assert_code_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !key_ready |=> $stable(key_code) || $past(acc_stb));

  // R8: overrun is sticky until the clear strobe
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !overrun_n && !stat_clr |=> !overrun_n);

  // R8: overrun only appears when a code was still pending
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun_n) |-> $past(key_valid) && !$past(key_ready));

  // R8: clear strobe without a coincident accept releases the flag
  assert_overrun_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !acc_stb |=> overrun_n);
endmodule

bind kbd_matrix_scanner kbd_matrix_scanner_chk #(
  .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_en  (scan_en),
  .scan_addr(scan_addr),
  .key_valid(key_valid),
  .key_ready(key_ready),
  .key_code (key_code),
  .overrun_n(overrun_n),
  .stat_clr (stat_clr),
  .smp_stb  (smp_stb),
  .acc_stb  (acc_stb)
);

// File: tb/kbd_matrix_scanner_tb_top.sv
`timescale 1ns/1ps
module kbd_matrix_scanner_tb_top;
  localparam int DW    = 4;
  localparam int SWEEP = 64 * DW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        scan_en = 1'b0;
  logic        debounce_en = 1'b0;
  logic [5:0]  scan_addr;
  logic        key_ret;
  logic        mod_ret;
  logic        key_valid;
  logic        key_ready = 1'b0;
  logic [7:0]  key_code;
  logic        irq;
  logic        held_n;
  logic        shift_n;
  logic        overrun_n;
  logic        stat_clr = 1'b0;

  logic [63:0] keys = '0;
  logic        shift_key = 1'b0;
  logic        ctrl_key = 1'b0;
  int          n_checks = 0;
  int          n_errors = 0;

  always #2.5 clk = ~clk;

  assign key_ret = keys[scan_addr];
  assign mod_ret = (scan_addr == 6'd62) ? shift_key :
                   (scan_addr == 6'd63) ? ctrl_key  : 1'b0;

  kbd_matrix_scanner #(.DWELL(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scan_en(scan_en),
    .debounce_en(debounce_en), .scan_addr(scan_addr), .key_ret(key_ret),
    .mod_ret(mod_ret), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .irq(irq), .held_n(held_n), .shift_n(shift_n),
    .overrun_n(overrun_n), .stat_clr(stat_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_sweeps(input int n);
    repeat (n * SWEEP) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic take_code();
    key_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    key_ready = 1'b0;
    check(key_valid == 1'b0, "R7 valid drops after handshake", key_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(scan_addr == 6'd0 && key_valid == 1'b0 && irq == 1'b0, "R1 reset outputs",
          {scan_addr, key_valid, irq}, 0);
    check(held_n && shift_n && overrun_n, "R1 reset status",
          {held_n, shift_n, overrun_n}, 7);
    rst_n = 1'b1;
    tick = 1'b1;
    scan_en = 1'b1;
  endtask

  task automatic t_addr_step();
    logic [5:0] hold_addr;
    repeat (DW - 1) @(posedge clk);
    @(negedge clk);
    check(scan_addr == 6'd0, "R2 address held for dwell", scan_addr, 0);
    @(posedge clk);
    @(negedge clk);
    check(scan_addr == 6'd1, "R2 address steps after dwell", scan_addr, 1);
    while (scan_addr != 6'd63) @(negedge clk);
    repeat (DW - 1) @(posedge clk);
    @(negedge clk);
    check(scan_addr == 6'd63, "R2 last address held", scan_addr, 63);
    @(posedge clk);
    @(negedge clk);
    check(scan_addr == 6'd0, "R2 wrap to zero", scan_addr, 0);
    tick = 1'b0;
    hold_addr = scan_addr;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(scan_addr == hold_addr, "R2 tick low freezes", scan_addr, hold_addr);
    tick = 1'b1;
  endtask

  task automatic t_disabled();
    logic [5:0] hold_addr;
    scan_en = 1'b0;
    hold_addr = scan_addr;
    keys[5] = 1'b1;
    repeat (2 * SWEEP) @(posedge clk);
    @(negedge clk);
    check(scan_addr == hold_addr, "R9 address frozen", scan_addr, hold_addr);
    check(key_valid == 1'b0, "R9 no accept while disabled", key_valid, 0);
    keys[5] = 1'b0;
    scan_en = 1'b1;
  endtask

  task automatic t_plain_accept();
    debounce_en = 1'b0;
    keys[6'h12] = 1'b1;
    wait_sweeps(1);
    check(key_valid && irq, "R3 request raised", {key_valid, irq}, 3);
    check(key_code == 8'h12, "R3 code is address", key_code, 8'h12);
    check(held_n == 1'b0, "R5 held after accept", held_n, 0);
    take_code();
    wait_sweeps(2);
    check(key_valid == 1'b0, "R10 held key not repeated", key_valid, 0);
    check(held_n == 1'b0, "R5 still held", held_n, 0);
    keys[6'h12] = 1'b0;
    wait_sweeps(1);
    check(held_n == 1'b1, "R5 release after one sweep", held_n, 1);
  endtask

  task automatic t_overrun();
    keys[6'h21] = 1'b1;
    wait_sweeps(1);
    check(key_valid && key_code == 8'h21, "R3 second key", key_code, 8'h21);
    wait_sweeps(1);
    check(key_valid && key_code == 8'h21 && overrun_n, "R7 code held under back-pressure",
          {overrun_n, key_code}, 9'h121);
    keys[6'h0A] = 1'b1;
    wait_sweeps(1);
    check(key_code == 8'h0A, "R8 newer code replaces", key_code, 8'h0A);
    check(overrun_n == 1'b0, "R8 overrun flagged", overrun_n, 0);
    take_code();
    check(overrun_n == 1'b0, "R8 overrun survives handshake", overrun_n, 0);
    stat_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stat_clr = 1'b0;
    check(overrun_n == 1'b1, "R8 clear strobe", overrun_n, 1);
    keys[6'h21] = 1'b0;
    keys[6'h0A] = 1'b0;
    wait_sweeps(1);
    check(held_n == 1'b1 && key_valid == 1'b0, "R5 both released", {held_n, key_valid}, 2);
  endtask

  task automatic t_debounce();
    debounce_en = 1'b1;
    keys[6'h15] = 1'b1;
    wait_sweeps(1);
    keys[6'h15] = 1'b0;
    wait_sweeps(3);
    check(key_valid == 1'b0, "R4 single-sweep press rejected", key_valid, 0);
    keys[6'h30] = 1'b1;
    wait_sweeps(1);
    check(key_valid == 1'b0, "R4 not accepted after one sweep", key_valid, 0);
    wait_sweeps(1);
    check(key_valid && key_code == 8'h30, "R4 accepted after two sweeps", key_code, 8'h30);
    take_code();
    keys[6'h30] = 1'b0;
    wait_sweeps(1);
    check(held_n == 1'b0, "R5 debounced: one release sweep keeps held", held_n, 0);
    wait_sweeps(1);
    check(held_n == 1'b1, "R5 debounced: released after two", held_n, 1);
    debounce_en = 1'b0;
    keys[6'h19] = 1'b1;
    wait_sweeps(1);
    keys[6'h19] = 1'b0;
    check(key_valid && key_code == 8'h19, "R3 single-sweep press accepted without debounce",
          key_code, 8'h19);
    take_code();
    wait_sweeps(1);
  endtask

  task automatic t_modifiers();
    shift_key = 1'b1;
    wait_sweeps(1);
    check(shift_n == 1'b0, "R6 shift status", shift_n, 0);
    keys[6'h07] = 1'b1;
    wait_sweeps(1);
    check(key_code == 8'h47, "R6 shift in bit 6", key_code, 8'h47);
    take_code();
    keys[6'h07] = 1'b0;
    shift_key = 1'b0;
    ctrl_key = 1'b1;
    wait_sweeps(1);
    check(shift_n == 1'b1, "R6 shift released", shift_n, 1);
    keys[6'h08] = 1'b1;
    wait_sweeps(1);
    check(key_code == 8'h88, "R6 control in bit 7", key_code, 8'h88);
    take_code();
    keys[6'h08] = 1'b0;
    ctrl_key = 1'b0;
    wait_sweeps(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_addr_step();
    t_disabled();
    t_plain_accept();
    t_overrun();
    t_debounce();
    t_modifiers();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule